// File: doc/BRIEF.md
# Serial Stereo Sample Deserializer

This block rebuilds 16-bit signed audio samples from a signal processor's bit-serial output port and places each finished word in a left or a right holding register. The serial clock, the data bit, an active-low output strobe, a port-select line and a ready qualifier all arrive synchronous to the system clock. The block finds the serial clock's rising edges by comparing its level with the level seen one system cycle earlier.

A small state machine runs the word. **IDLE** waits for a start: a rising serial edge while `rdy_i` is high and `strobe_n_i` is low. That edge moves it to **SHIFT** (transition *start*). At the same edge it latches `port_sel_i` as the channel (0 = left, 1 = right), presets a 16-bit bit mask to all ones and takes in the first bit. **SHIFT** takes one bit per rising edge and moves the mask one place right each time. When the mask empties it moves to **COMMIT** (transition *last_bit*). **COMMIT** writes the word into the captured channel's register, pulses that channel's valid output for one cycle, and returns to **IDLE** (transition *written*).

The source sends a stereo pair about every 41.6 µs (24.038 kHz per channel) with a 5 MHz serial clock. An idle frame sits between the left and right words, so the block never sees two words back to back without a gap. The left valid pulse also marks the point at which a stereo frame is complete and downstream output may be updated.

Top module: `stereo_ser_rx`

## Requirements
- R1: A synchronous reset clears both sample registers to 0, drops both valid outputs and returns the machine to IDLE, even when the reset arrives in the middle of a word.
- R2: A word starts on a rising serial edge only when the machine is in IDLE, `rdy_i` is 1 and `strobe_n_i` is 0.
- R3: With `rdy_i` at 0 or `strobe_n_i` at 1, rising serial edges in IDLE start no word: neither register changes and no valid pulse appears.
- R4: Once a word has started, changes on `port_sel_i`, `rdy_i` and `strobe_n_i` have no effect on it. The channel sampled at the start edge is the one written.
- R5: A word is exactly 16 bits, one per rising serial edge, including the start edge. The bits are taken LSB first, so the first bit received lands in bit 0 and the sixteenth in bit 15.
- R6: A finished word goes only to the register of the captured channel: channel 0 writes `left_o` and channel 1 writes `right_o`. The other register keeps its value.
- R7: Each finished word raises exactly one one-cycle valid pulse, on the written channel's output only. The two valid outputs are never high together.
- R8: Only rising serial edges move the word forward. A serial clock held high for many system cycles counts as one bit.
- R9: A new word can start on the first rising serial edge after the machine has returned to IDLE. Two words separated by one low serial phase are both stored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sclk_i | input | 1 | Serial bit clock from the signal processor |
| sdata_i | input | 1 | Serial data bit |
| strobe_n_i | input | 1 | Active-low output strobe that qualifies a word start |
| port_sel_i | input | 1 | Port-select line, sampled at word start as the channel (0 left, 1 right) |
| rdy_i | input | 1 | Ready qualifier for word starts |
| left_o | output | 16 | Last left-channel sample |
| right_o | output | 16 | Last right-channel sample |
| left_vld_o | output | 1 | One-cycle pulse when `left_o` is written; also marks a complete stereo frame |
| right_vld_o | output | 1 | One-cycle pulse when `right_o` is written |

## Verification
The assertions assume that every serial input is already synchronous to the system clock. They also assume each serial clock phase lasts at least one system cycle, so no rising edge falls inside the single COMMIT cycle. The bench respects both assumptions. It changes every input on the falling system edge and holds each serial phase for two or more system cycles. Its tightest case, back-to-back words, still leaves the restart edge several cycles after COMMIT.

// File: rtl/sdes_pkg.sv
package sdes_pkg;
    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_SHIFT  = 2'd1,
        S_COMMIT = 2'd2
    } sdes_state_t;

    localparam int unsigned NUM_CH = 2;
endpackage

// File: rtl/sdes_edge.sv
module sdes_edge (
    input  logic clk,
    input  logic rst,
    input  logic sclk_i,
    output logic rise_o
);
    logic sclk_q;

    always_ff @(posedge clk) begin
        if (rst) sclk_q <= 1'b1;
        else     sclk_q <= sclk_i;
    end

    assign rise_o = sclk_i & ~sclk_q;

    p_rise_single_r8: assert property (@(posedge clk) disable iff (rst)
        rise_o |=> !rise_o);
endmodule

// File: rtl/sdes_shifter.sv
module sdes_shifter
    import sdes_pkg::*;
#(
    parameter int unsigned WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rise_i,
    input  logic              sdata_i,
    input  logic              strobe_n_i,
    input  logic              rdy_i,
    input  logic              port_sel_i,
    output logic [WORD_W-1:0] word_o,
    output logic              chan_o,
    output logic              commit_o
);
    localparam logic [WORD_W-1:0] MASK_FULL = '1;

    sdes_state_t      state_q, state_d;
    logic [WORD_W-1:0] mask_q;
    logic [WORD_W-1:0] sr_q;
    logic              chan_q;
    logic              start_ok;

    assign start_ok = rise_i && rdy_i && !strobe_n_i;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (start_ok) state_d = S_SHIFT;
            S_SHIFT:  if (rise_i && mask_q == {{(WORD_W-1){1'b0}}, 1'b1}) state_d = S_COMMIT;
            S_COMMIT: state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= S_IDLE;
        else     state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
            sr_q   <= '0;
            chan_q <= 1'b0;
        end else begin
            unique case (state_q)
                S_IDLE: if (start_ok) begin
                    chan_q <= port_sel_i;
                    mask_q <= MASK_FULL >> 1;
                    sr_q   <= {sdata_i, sr_q[WORD_W-1:1]};
                end
                S_SHIFT: if (rise_i) begin
                    mask_q <= mask_q >> 1;
                    sr_q   <= {sdata_i, sr_q[WORD_W-1:1]};
                end
                S_COMMIT: mask_q <= '0;
                default:  mask_q <= '0;
            endcase
        end
    end

    assign word_o   = sr_q;
    assign chan_o   = chan_q;
    assign commit_o = (state_q == S_COMMIT);

    p_start_qualified_r2: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_SHIFT && $past(state_q) == S_IDLE) |-> ($past(rdy_i) && !$past(strobe_n_i)));
    p_chan_held_r4: assert property (@(posedge clk) disable iff (rst)
        (state_q != S_IDLE && $past(state_q) != S_IDLE) |-> $stable(chan_q));
    p_commit_after_shift_r5: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_COMMIT) |-> ($past(state_q) == S_SHIFT && $past(rise_i)));
    p_mask_live_r5: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_SHIFT) |-> (mask_q != '0));
endmodule

// File: rtl/sdes_store.sv
module sdes_store
    import sdes_pkg::*;
#(
    parameter int unsigned WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              commit_i,
    input  logic              chan_i,
    input  logic [WORD_W-1:0] word_i,
    output logic [WORD_W-1:0] left_o,
    output logic [WORD_W-1:0] right_o,
    output logic              left_vld_o,
    output logic              right_vld_o
);
    logic [WORD_W-1:0] hold_q [NUM_CH];
    logic [NUM_CH-1:0] vld_q;

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        always_ff @(posedge clk) begin
            if (rst) begin
                hold_q[ch] <= '0;
                vld_q[ch]  <= 1'b0;
            end else begin
                vld_q[ch] <= commit_i && (chan_i == ch[0]);
                if (commit_i && (chan_i == ch[0])) hold_q[ch] <= word_i;
            end
        end
    end

    assign left_o      = hold_q[0];
    assign right_o     = hold_q[1];
    assign left_vld_o  = vld_q[0];
    assign right_vld_o = vld_q[1];

    p_excl_vld_r7: assert property (@(posedge clk) disable iff (rst)
        !(left_vld_o && right_vld_o));
    p_left_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        left_vld_o |=> !left_vld_o);
    p_right_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        right_vld_o |=> !right_vld_o);
    p_other_kept_r6: assert property (@(posedge clk) disable iff (rst)
        left_vld_o |-> $stable(right_o));
    p_only_on_vld_r6: assert property (@(posedge clk) disable iff (rst)
        (!left_vld_o && !$past(rst)) |-> $stable(left_o));
endmodule

// File: rtl/stereo_ser_rx.sv
module stereo_ser_rx #(
    parameter int unsigned WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sclk_i,
    input  logic              sdata_i,
    input  logic              strobe_n_i,
    input  logic              port_sel_i,
    input  logic              rdy_i,
    output logic [WORD_W-1:0] left_o,
    output logic [WORD_W-1:0] right_o,
    output logic              left_vld_o,
    output logic              right_vld_o
);
    logic              rise;
    logic [WORD_W-1:0] word;
    logic              chan;
    logic              commit;

    sdes_edge u_edge (
        .clk    (clk),
        .rst    (rst),
        .sclk_i (sclk_i),
        .rise_o (rise)
    );

    sdes_shifter #(.WORD_W(WORD_W)) u_shift (
        .clk        (clk),
        .rst        (rst),
        .rise_i     (rise),
        .sdata_i    (sdata_i),
        .strobe_n_i (strobe_n_i),
        .rdy_i      (rdy_i),
        .port_sel_i (port_sel_i),
        .word_o     (word),
        .chan_o     (chan),
        .commit_o   (commit)
    );

    sdes_store #(.WORD_W(WORD_W)) u_store (
        .clk         (clk),
        .rst         (rst),
        .commit_i    (commit),
        .chan_i      (chan),
        .word_i      (word),
        .left_o      (left_o),
        .right_o     (right_o),
        .left_vld_o  (left_vld_o),
        .right_vld_o (right_vld_o)
    );
endmodule

// File: tb/tb_stereo_ser_rx.sv
module tb_stereo_ser_rx;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sclk = 1'b0;
    logic        sdata = 1'b0;
    logic        strobe_n = 1'b1;
    logic        psel = 1'b0;
    logic        rdy = 1'b0;
    logic [15:0] left_q, right_q;
    logic        left_v, right_v;

    int checks = 0;
    int errors = 0;
    int lcnt = 0;
    int rcnt = 0;
    bit both_seen = 1'b0;

    always #2 clk = ~clk;

    stereo_ser_rx dut (
        .clk(clk), .rst(rst), .sclk_i(sclk), .sdata_i(sdata),
        .strobe_n_i(strobe_n), .port_sel_i(psel), .rdy_i(rdy),
        .left_o(left_q), .right_o(right_q),
        .left_vld_o(left_v), .right_vld_o(right_v)
    );

    always @(negedge clk) begin
        if (left_v)  lcnt++;
        if (right_v) rcnt++;
        if (left_v && right_v) both_seen = 1'b1;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    // one word on the serial port; flip changes qualifiers after bit 0,
    // longhi holds the clock high for a long time on bit 5
    task automatic send_word(input logic [15:0] d, input logic ch, input logic r,
                             input logic sn, input bit flip, input bit longhi);
        @(negedge clk);
        psel = ch; rdy = r; strobe_n = sn;
        for (int i = 0; i < 16; i++) begin
            sclk = 1'b0; sdata = d[i];
            if (flip && i == 1) begin psel = ~ch; rdy = 1'b0; strobe_n = 1'b1; end
            clks(2);
            sclk = 1'b1;
            clks((longhi && i == 5) ? 12 : 2);
        end
        sclk = 1'b0;
    endtask

    task automatic idle_gap();
        strobe_n = 1'b1; rdy = 1'b1; sclk = 1'b0;
        clks(6);
    endtask

    task automatic t_reset();
        chk("R1 left after reset", left_q, 0);
        chk("R1 right after reset", right_q, 0);
        chk("R1 valids after reset", {left_v, right_v}, 0);
    endtask

    task automatic t_left();
        int l0 = lcnt, r0 = rcnt;
        send_word(16'hA55A, 1'b0, 1'b1, 1'b0, 0, 0); idle_gap();
        chk("R2 R6 left word", left_q, 16'hA55A);
        chk("R6 right untouched", right_q, 0);
        chk("R7 one left pulse", lcnt - l0, 1);
        chk("R7 no right pulse", rcnt - r0, 0);
    endtask

    task automatic t_right_lsb();
        int l0 = lcnt, r0 = rcnt;
        send_word(16'h8001, 1'b1, 1'b1, 1'b0, 0, 0); idle_gap();
        chk("R5 LSB-first right word", right_q, 16'h8001);
        chk("R6 left kept", left_q, 16'hA55A);
        chk("R7 one right pulse", rcnt - r0, 1);
        chk("R7 no left pulse", lcnt - l0, 0);
    endtask

    task automatic t_blocked();
        int l0 = lcnt, r0 = rcnt;
        send_word(16'hFFFF, 1'b0, 1'b0, 1'b0, 0, 0); idle_gap();
        chk("R3 rdy low blocks", left_q, 16'hA55A);
        send_word(16'hFFFF, 1'b1, 1'b1, 1'b1, 0, 0); idle_gap();
        chk("R3 strobe high blocks", right_q, 16'h8001);
        chk("R3 no pulses", (lcnt - l0) + (rcnt - r0), 0);
    endtask

    task automatic t_hold_chan();
        int l0 = lcnt;
        send_word(16'h3C96, 1'b1, 1'b1, 1'b0, 1, 0); idle_gap();
        chk("R4 channel from start edge", right_q, 16'h3C96);
        chk("R4 left unaffected", left_q, 16'hA55A);
        chk("R4 no left pulse", lcnt - l0, 0);
    endtask

    task automatic t_long_high();
        send_word(16'h0F0F, 1'b0, 1'b1, 1'b0, 0, 1); idle_gap();
        chk("R8 long high is one bit", left_q, 16'h0F0F);
    endtask

    task automatic t_back_to_back();
        int l0 = lcnt, r0 = rcnt;
        send_word(16'h1234, 1'b0, 1'b1, 1'b0, 0, 0);
        clks(2);
        send_word(16'hFEDC, 1'b1, 1'b1, 1'b0, 0, 0); idle_gap();
        chk("R9 first word kept", left_q, 16'h1234);
        chk("R9 second word kept", right_q, 16'hFEDC);
        chk("R9 two pulses", (lcnt - l0) * 10 + (rcnt - r0), 11);
    endtask

    task automatic t_reset_mid();
        @(negedge clk);
        psel = 1'b0; rdy = 1'b1; strobe_n = 1'b0;
        for (int i = 0; i < 6; i++) begin
            sclk = 1'b0; sdata = 1'b1; clks(2); sclk = 1'b1; clks(2);
        end
        rst = 1'b1; clks(2); rst = 1'b0; sclk = 1'b0; strobe_n = 1'b1;
        clks(2);
        chk("R1 mid-word reset left", left_q, 0);
        chk("R1 mid-word reset right", right_q, 0);
        send_word(16'h5A5A, 1'b0, 1'b1, 1'b0, 0, 0); idle_gap();
        chk("R1 fresh word after reset", left_q, 16'h5A5A);
    endtask

    bit done = 1'b0;

    initial begin
        clks(4);
        rst = 1'b0;
        clks(2);
        t_reset();
        t_left();
        t_right_lsb();
        t_blocked();
        t_hold_chan();
        t_long_high();
        t_back_to_back();
        t_reset_mid();
        chk("R7 valids never together", both_seen, 0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule